// File: doc/BRIEF.md
# Security-Gated Auxiliary Control Register

This block holds a 32-bit auxiliary control word for a processor core. The word carries enables for parity, single-way allocation, exclusive caching with the next cache level, coherency participation, zero-line write optimisation, two prefetch hints and broadcast of maintenance operations. Software reaches the word through a single-cycle access strobe. Each access carries a direction, a privilege flag and a security-state flag. Two side inputs also gate writes: a Non-secure write enable and a lock on Secure configuration.

Illegal accesses raise a fault pulse in the same cycle as the access, and the stored value does not change. The block also drives qualifiers that the cache and coherency logic use. One qualifier makes Inner Cacheable Shareable accesses non-cacheable while coherency participation is off. Two others permit sending and receiving maintenance broadcasts. Two build parameters set whether parity is implemented and how many cores share the cluster.

Top module: `aux_ctrl_reg`

## Requirements
- R1: After reset every stored bit is 0, `rdData` is 0, `icsNonCacheable` is 1 and both broadcast permissions are 0.
- R2: An access with `accPriv` low, read or write, raises `undefFault` in the same cycle, leaves the stored word unchanged and leaves `rdData` unchanged.
- R3: A privileged Secure write with `secLock` low stores `wrData` on the implemented bits. Bits [31:10] and [5:4] always read as 0.
- R4: A privileged Non-secure write with `nsWriteEn` low changes nothing and raises no fault.
- R5: A privileged Non-secure write with `nsWriteEn` high updates only bit 6 (coherency participation). It raises no fault.
- R6: A privileged Secure write with `secLock` high leaves the word unchanged and raises `undefFault` in that cycle.
- R7: With `PARITY_IMPL` = 0, bit 9 (parity enable) reads as 0 and ignores writes. With `PARITY_IMPL` = 1, bit 9 is writable.
- R8: With `NUM_CORES` = 1, bit 0 (maintenance broadcast) reads as 0 and ignores writes, and both broadcast permissions stay 0.
- R9: `icsNonCacheable` is 1 exactly when bit 6 is 0.
- R10: In a multi-core build, `bcastSendOk` and `bcastRecvOk` are 1 exactly when bits 6 and 0 are both 1.
- R11: A privileged read, in either security state and regardless of `secLock`, raises no fault and presents the stored word on `rdData` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe, one cycle per access |
| accWrite | input | 1 | 1 = write, 0 = read |
| accPriv | input | 1 | Access comes from a privileged mode |
| accSecure | input | 1 | Access comes from Secure state |
| nsWriteEn | input | 1 | Non-secure write enable for the coherency bit |
| secLock | input | 1 | Lock on Secure configuration writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| undefFault | output | 1 | Undefined-instruction pulse, same cycle as the access |
| icsNonCacheable | output | 1 | Treat Inner Cacheable Shareable accesses as non-cacheable |
| bcastSendOk | output | 1 | Permission to send maintenance broadcasts |
| bcastRecvOk | output | 1 | Permission to accept maintenance broadcasts |

## Verification
The bench builds two copies of the block from the same stimulus. The first copy has parity implemented and four cores, so bits 9 and 0 are writable and the broadcast permissions can be reached. The second copy has no parity and a single core, which shows bits 9 and 0 reading as zero and the permissions held low. Driving both copies side by side shows that a write of all ones leaves different stored words depending only on the build parameters.

// File: rtl/aux_ctrl_pkg.sv
package aux_ctrl_pkg;
  localparam int DATA_W     = 32;
  localparam int BIT_PARITY = 9;
  localparam int BIT_ONEWAY = 8;
  localparam int BIT_EXCL   = 7;
  localparam int BIT_COH    = 6;
  localparam int BIT_ZLINE  = 3;
  localparam int BIT_L1PF   = 2;
  localparam int BIT_L2PF   = 1;
  localparam int BIT_BCAST  = 0;

  typedef struct packed {
    logic wrAll;
    logic wrCohOnly;
    logic rdLoad;
  } ctlStrobes_t;

  function automatic logic [DATA_W-1:0] implMask(input bit parityImpl, input int numCores);
    logic [DATA_W-1:0] m;
    m = '0;
    m[BIT_ONEWAY] = 1'b1;
    m[BIT_EXCL]   = 1'b1;
    m[BIT_COH]    = 1'b1;
    m[BIT_ZLINE]  = 1'b1;
    m[BIT_L1PF]   = 1'b1;
    m[BIT_L2PF]   = 1'b1;
    m[BIT_PARITY] = parityImpl;
    m[BIT_BCAST]  = (numCores > 1);
    return m;
  endfunction
endpackage

// File: rtl/aux_ctrl_ctl.sv
module aux_ctrl_ctl
  import aux_ctrl_pkg::*;
(
  input  logic        accValid,
  input  logic        accWrite,
  input  logic        accPriv,
  input  logic        accSecure,
  input  logic        nsWriteEn,
  input  logic        secLock,
  output ctlStrobes_t strobes,
  output logic        undefFault
);
  logic privAcc;
  logic secWrite;
  logic nsWrite;

  always_comb begin
    privAcc  = accValid & accPriv;
    secWrite = privAcc & accWrite & accSecure;
    nsWrite  = privAcc & accWrite & ~accSecure;

    strobes.wrAll     = secWrite & ~secLock;
    strobes.wrCohOnly = nsWrite & nsWriteEn;
    strobes.rdLoad    = privAcc & ~accWrite;

    undefFault = accValid & (~accPriv | (accWrite & accSecure & secLock));
  end
endmodule

// File: rtl/aux_ctrl_dp.sv
module aux_ctrl_dp
  import aux_ctrl_pkg::*;
#(
  parameter bit PARITY_IMPL = 1'b1,
  parameter int NUM_CORES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ctrlQ,
  output logic [DATA_W-1:0] rdData,
  output logic              icsNonCacheable,
  output logic              bcastSendOk,
  output logic              bcastRecvOk
);
  localparam logic [DATA_W-1:0] IMPL_MASK = implMask(PARITY_IMPL, NUM_CORES);

  logic [DATA_W-1:0] ctrlD;

  always_comb begin
    ctrlD = ctrlQ;
    if (strobes.wrAll) begin
      ctrlD = wrData & IMPL_MASK;
    end else if (strobes.wrCohOnly) begin
      ctrlD[BIT_COH] = wrData[BIT_COH];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      rdData <= '0;
    end else begin
      ctrlQ <= ctrlD;
      if (strobes.rdLoad) rdData <= ctrlQ;
    end
  end

  logic bcastOk;

  generate
    if (NUM_CORES > 1) begin : g_multi
      assign bcastOk = ctrlQ[BIT_COH] & ctrlQ[BIT_BCAST];
    end else begin : g_single
      assign bcastOk = 1'b0;
    end
  endgenerate

  assign icsNonCacheable = ~ctrlQ[BIT_COH];
  assign bcastSendOk     = bcastOk;
  assign bcastRecvOk     = bcastOk;
endmodule

// File: rtl/aux_ctrl_reg.sv
module aux_ctrl_reg
  import aux_ctrl_pkg::*;
#(
  parameter bit PARITY_IMPL = 1'b1,
  parameter int NUM_CORES   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic        accWrite,
  input  logic        accPriv,
  input  logic        accSecure,
  input  logic        nsWriteEn,
  input  logic        secLock,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        undefFault,
  output logic        icsNonCacheable,
  output logic        bcastSendOk,
  output logic        bcastRecvOk
);
  ctlStrobes_t       strobes;
  logic [DATA_W-1:0] ctrlQ;

  aux_ctrl_ctl u_ctl (
    .accValid   (accValid),
    .accWrite   (accWrite),
    .accPriv    (accPriv),
    .accSecure  (accSecure),
    .nsWriteEn  (nsWriteEn),
    .secLock    (secLock),
    .strobes    (strobes),
    .undefFault (undefFault)
  );

  aux_ctrl_dp #(
    .PARITY_IMPL (PARITY_IMPL),
    .NUM_CORES   (NUM_CORES)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .wrData          (wrData),
    .ctrlQ           (ctrlQ),
    .rdData          (rdData),
    .icsNonCacheable (icsNonCacheable),
    .bcastSendOk     (bcastSendOk),
    .bcastRecvOk     (bcastRecvOk)
  );
endmodule

// File: rtl/aux_ctrl_chk.sv
module aux_ctrl_chk #(
  parameter bit PARITY_IMPL = 1'b1,
  parameter int NUM_CORES   = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        accValid,
  input logic        accWrite,
  input logic        accPriv,
  input logic        accSecure,
  input logic        nsWriteEn,
  input logic        secLock,
  input logic [31:0] ctrlQ,
  input logic [31:0] rdData,
  input logic        undefFault,
  input logic        icsNonCacheable,
  input logic        bcastSendOk,
  input logic        bcastRecvOk
);
  logic unprivAcc, lockedWr, nsBlockedWr, nsCohWr, legalRd;
  assign unprivAcc   = accValid & ~accPriv;
  assign lockedWr    = accValid & accPriv & accWrite & accSecure & secLock;
  assign nsBlockedWr = accValid & accPriv & accWrite & ~accSecure & ~nsWriteEn;
  assign nsCohWr     = accValid & accPriv & accWrite & ~accSecure & nsWriteEn;
  assign legalRd     = accValid & accPriv & ~accWrite;

  a_r2_unpriv_fault: assert property (@(posedge clk) disable iff (!rstN)
    unprivAcc |-> undefFault);
  a_r2_unpriv_hold: assert property (@(posedge clk) disable iff (!rstN)
    unprivAcc |=> ($stable(ctrlQ) && $stable(rdData)));
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[31:10] == '0) && (ctrlQ[5:4] == 2'b00));
  a_r4_ns_ignored: assert property (@(posedge clk) disable iff (!rstN)
    nsBlockedWr |=> $stable(ctrlQ));
  a_r4_ns_nofault: assert property (@(posedge clk) disable iff (!rstN)
    nsBlockedWr |-> !undefFault);
  a_r5_coh_only: assert property (@(posedge clk) disable iff (!rstN)
    nsCohWr |=> ((ctrlQ[31:7] == $past(ctrlQ[31:7])) && (ctrlQ[5:0] == $past(ctrlQ[5:0]))));
  a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rstN)
    lockedWr |=> $stable(ctrlQ));
  a_r6_lock_fault: assert property (@(posedge clk) disable iff (!rstN)
    lockedWr |-> undefFault);
  a_r7_parity_absent: assert property (@(posedge clk) disable iff (!rstN)
    (PARITY_IMPL != 1'b0) || !ctrlQ[9]);
  a_r8_single_core: assert property (@(posedge clk) disable iff (!rstN)
    (NUM_CORES > 1) || (!ctrlQ[0] && !bcastSendOk && !bcastRecvOk));
  a_r9_noncache: assert property (@(posedge clk) disable iff (!rstN)
    icsNonCacheable != ctrlQ[6]);
  a_r10_bcast_qual: assert property (@(posedge clk) disable iff (!rstN)
    (bcastSendOk || bcastRecvOk) |-> (ctrlQ[6] && ctrlQ[0] && bcastSendOk == bcastRecvOk));
  a_r11_read_data: assert property (@(posedge clk) disable iff (!rstN)
    legalRd |=> (rdData == $past(ctrlQ)));
  a_r11_read_nofault: assert property (@(posedge clk) disable iff (!rstN)
    legalRd |-> !undefFault);
endmodule

bind aux_ctrl_reg aux_ctrl_chk #(
  .PARITY_IMPL (PARITY_IMPL),
  .NUM_CORES   (NUM_CORES)
) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .accValid        (accValid),
  .accWrite        (accWrite),
  .accPriv         (accPriv),
  .accSecure       (accSecure),
  .nsWriteEn       (nsWriteEn),
  .secLock         (secLock),
  .ctrlQ           (ctrlQ),
  .rdData          (rdData),
  .undefFault      (undefFault),
  .icsNonCacheable (icsNonCacheable),
  .bcastSendOk     (bcastSendOk),
  .bcastRecvOk     (bcastRecvOk)
);

// File: tb/tb_aux_ctrl_reg.sv
`timescale 1ns/1ps
module tb_aux_ctrl_reg;
  localparam logic [31:0] MASK_FULL = 32'h0000_03CF;
  localparam logic [31:0] MASK_MIN  = 32'h0000_01CE;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0, accWrite = 1'b0, accPriv = 1'b0, accSecure = 1'b0;
  logic        nsWriteEn = 1'b0, secLock = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdDataMin;
  logic        undefFault, undefFaultMin;
  logic        icsNc, icsNcMin, sendOk, sendOkMin, recvOk, recvOkMin;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] expFull = '0;
  logic [31:0] expMin = '0;

  always #2.5 clk = ~clk;

  aux_ctrl_reg #(.PARITY_IMPL(1'b1), .NUM_CORES(4)) dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accPriv(accPriv), .accSecure(accSecure), .nsWriteEn(nsWriteEn),
    .secLock(secLock), .wrData(wrData), .rdData(rdData),
    .undefFault(undefFault), .icsNonCacheable(icsNc),
    .bcastSendOk(sendOk), .bcastRecvOk(recvOk));

  aux_ctrl_reg #(.PARITY_IMPL(1'b0), .NUM_CORES(1)) dutMin (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accPriv(accPriv), .accSecure(accSecure), .nsWriteEn(nsWriteEn),
    .secLock(secLock), .wrData(wrData), .rdData(rdDataMin),
    .undefFault(undefFaultMin), .icsNonCacheable(icsNcMin),
    .bcastSendOk(sendOkMin), .bcastRecvOk(recvOkMin));

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one access at a negedge, check fault mid-cycle, release after the edge.
  task automatic access(input bit wr, input bit priv, input bit sec, input logic [31:0] data,
                        input bit expFault, input string req);
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; accPriv = priv; accSecure = sec; wrData = data;
    #1;
    check(req, "fault", {31'b0, undefFault}, {31'b0, expFault});
    check(req, "fault min", {31'b0, undefFaultMin}, {31'b0, expFault});
    @(posedge clk);
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0; wrData = '0;
  endtask

  task automatic readBack(input string req);
    access(1'b0, 1'b1, 1'b1, '0, 1'b0, req);
    check(req, "rdData", rdData, expFull);
    check(req, "rdData min", rdDataMin, expMin);
  endtask

  task automatic checkQuals(input string req);
    logic b;
    b = expFull[6] & expFull[0];
    check(req, "icsNc", {31'b0, icsNc}, {31'b0, ~expFull[6]});
    check(req, "icsNc min", {31'b0, icsNcMin}, {31'b0, ~expMin[6]});
    check(req, "send", {31'b0, sendOk}, {31'b0, b});
    check(req, "recv", {31'b0, recvOk}, {31'b0, b});
    check("R8", "send min", {31'b0, sendOkMin}, 32'b0);
    check("R8", "recv min", {31'b0, recvOkMin}, 32'b0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "rdData", rdData, '0);
    check("R1", "fault", {31'b0, undefFault}, 32'b0);
    checkQuals("R1");
    readBack("R1");
  endtask

  task automatic t_secure_write();
    access(1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, "R3");
    expFull = MASK_FULL; expMin = MASK_MIN;
    readBack("R3");
    readBack("R7");
    checkQuals("R10");
    access(1'b1, 1'b1, 1'b1, 32'h0000_0235, 1'b0, "R3");
    expFull = 32'h0000_0205; expMin = 32'h0000_0004;
    readBack("R3");
    checkQuals("R9");
  endtask

  task automatic t_unpriv();
    access(1'b1, 1'b1, 1'b1, 32'h0000_03CF, 1'b0, "R3");
    expFull = MASK_FULL; expMin = MASK_MIN;
    readBack("R2");
    access(1'b1, 1'b0, 1'b1, 32'h0, 1'b1, "R2");
    access(1'b1, 1'b0, 1'b0, 32'h0, 1'b1, "R2");
    checkQuals("R2");
    // Change stored word, then an unprivileged read must not refresh rdData.
    access(1'b1, 1'b1, 1'b1, 32'h0000_0100, 1'b0, "R3");
    access(1'b0, 1'b0, 1'b1, 32'h0, 1'b1, "R2");
    check("R2", "rdData held", rdData, MASK_FULL);
    check("R2", "rdData min held", rdDataMin, MASK_MIN);
    expFull = 32'h0000_0100; expMin = 32'h0000_0100;
    readBack("R2");
  endtask

  task automatic t_lock();
    secLock = 1'b1;
    access(1'b1, 1'b1, 1'b1, 32'h0000_03CF, 1'b1, "R6");
    readBack("R11");
    access(1'b0, 1'b1, 1'b0, '0, 1'b0, "R11");
    check("R11", "ns read", rdData, expFull);
    secLock = 1'b0;
    readBack("R6");
  endtask

  task automatic t_ns_blocked();
    access(1'b1, 1'b1, 1'b1, 32'h0000_03CF, 1'b0, "R3");
    expFull = MASK_FULL; expMin = MASK_MIN;
    nsWriteEn = 1'b0;
    access(1'b1, 1'b1, 1'b0, 32'h0, 1'b0, "R4");
    readBack("R4");
    checkQuals("R4");
  endtask

  task automatic t_ns_coh();
    nsWriteEn = 1'b1;
    access(1'b1, 1'b1, 1'b0, 32'h0, 1'b0, "R5");
    expFull = MASK_FULL & ~32'h40; expMin = MASK_MIN & ~32'h40;
    readBack("R5");
    checkQuals("R5");
    access(1'b1, 1'b1, 1'b1, 32'h0, 1'b0, "R3");
    access(1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, "R5");
    expFull = 32'h40; expMin = 32'h40;
    readBack("R5");
    checkQuals("R9");
    nsWriteEn = 1'b0;
  endtask

  task automatic t_bcast();
    access(1'b1, 1'b1, 1'b1, 32'h0000_0041, 1'b0, "R10");
    expFull = 32'h41; expMin = 32'h40;
    checkQuals("R10");
    access(1'b1, 1'b1, 1'b1, 32'h0000_0001, 1'b0, "R10");
    expFull = 32'h01; expMin = 32'h00;
    checkQuals("R10");
    readBack("R8");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    t_reset();
    t_secure_write();
    t_unpriv();
    t_lock();
    t_ns_blocked();
    t_ns_coh();
    t_bcast();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule